// File: doc/BRIEF.md
# USB Device Command Port

This block sits between a small microcontroller and the protocol engine of a USB device controller. The microcontroller writes one command byte at a time through a parallel strobe. Where a command has a read phase, it then collects the reply bytes with a read strobe. The block keeps the frame number taken from the most recent start-of-frame packet that arrived without error. It also holds the full flag of one IN endpoint buffer, which tells the protocol engine whether to answer the host with data or with a NAK.

Two commands are decoded. The frame-number command opens a read phase of up to two bytes. The first byte is the low eight bits. The second byte carries the upper frame bits, padded with zeros. The reader may stop after the first byte. The validate command takes no data and marks the IN buffer as ready. Packet decoding, CRC checking, bit serialisation and the buffer memory itself are handled outside this block.

Top module: `usb_cmd_port`

## Requirements
- R1: After synchronous reset, buf_full is 0 and the stored frame number is 0. A frame-number command followed by two reads then returns 00h and 00h.
- R2: A sof_valid pulse stores sof_frame (11 bits). A later frame-number read returns the value from the most recent pulse.
- R3: After command byte F5h, the first read returns bits 7:0 of the stored frame number.
- R4: The second read after F5h returns the upper 3 frame bits in rd_data bits 2:0, with rd_data bits 7:3 equal to zero.
- R5: The full frame number is captured when the first byte is read. A sof_valid pulse between the first and second reads does not change the second byte.
- R6: A reader may stop after one byte. Any following command byte starts afresh, so a new F5h again returns the low byte first.
- R7: A read with no pending read phase returns 00h and changes nothing. This covers a third read after F5h and a read after FAh.
- R8: Command byte FAh sets buf_full, which is visible from the cycle after the write.
- R9: An in_token pulse while buf_full is 1 gives a one-cycle in_reply_data pulse in the next cycle, and buf_full stays 1.
- R10: An in_token pulse while buf_full is 0 gives a one-cycle in_reply_nak pulse in the next cycle, and no in_reply_data pulse.
- R11: A host_ack pulse clears buf_full in the next cycle. If FAh is written in the same cycle as host_ack, buf_full stays 1.
- R12: rd_data is 00h in every cycle in which rd_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command code |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| sof_valid | input | 1 | Error-free start-of-frame seen |
| sof_frame | input | FRAME_W | Frame number from that packet |
| in_token | input | 1 | IN token received for the endpoint |
| host_ack | input | 1 | Host acknowledged the IN data |
| buf_full | output | 1 | IN buffer armed for sending |
| in_reply_data | output | 1 | Answer the token with buffer data |
| in_reply_nak | output | 1 | Answer the token with NAK |

## Verification
The bench uses the default parameters: an 11-bit frame number with command codes FAh and F5h. With these values, a few frame numbers cover the all-zero value, the all-ones value 7FFh, and values whose only set bits lie in the upper three bits. This exercises the zero padding of the second byte and the split between the two bytes. The bench also puts a start-of-frame pulse between the two reads, checking that the value does not tear. It writes the validate command and a host acknowledge in the same cycle to check which one wins.

// File: rtl/usb_cmd_port_pkg.sv
package usb_cmd_port_pkg;

    localparam int BYTE_W        = 8;
    localparam int FRAME_W_DEF   = 11;
    localparam logic [7:0] OP_ARM_IN    = 8'hFA;
    localparam logic [7:0] OP_GET_FRAME = 8'hF5;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2
    } rd_phase_e;

    typedef struct packed {
        logic arm;
        logic get_frame;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_op(input logic [7:0] op,
                                           input logic [7:0] arm_code,
                                           input logic [7:0] frame_code);
        cmd_dec_t d;
        d.arm       = (op == arm_code);
        d.get_frame = (op == frame_code);
        return d;
    endfunction

endpackage

// File: rtl/usbcp_frame_reg.sv
module usbcp_frame_reg #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    output logic [FRAME_W-1:0] frame_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (sof_valid) begin
            frame_q <= sof_frame;
        end
    end
endmodule

// File: rtl/usbcp_cmd_seq.sv
module usbcp_cmd_seq
    import usb_cmd_port_pkg::*;
#(
    parameter int         FRAME_W    = 11,
    parameter logic [7:0] CODE_ARM   = OP_ARM_IN,
    parameter logic [7:0] CODE_FRAME = OP_GET_FRAME
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_wr,
    input  logic [7:0]         cmd_byte,
    input  logic               rd_en,
    input  logic [FRAME_W-1:0] frame_q,
    output logic [7:0]         rd_data,
    output logic               arm_pulse
);
    localparam int HI_W  = FRAME_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;

    rd_phase_e       phase_q;
    logic [HI_W-1:0] hi_snap_q;
    cmd_dec_t        dec;
    logic [7:0]      rd_val;

    assign dec       = decode_op(cmd_byte, CODE_ARM, CODE_FRAME);
    assign arm_pulse = cmd_wr && dec.arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            hi_snap_q <= '0;
        end else if (cmd_wr) begin
            phase_q <= dec.get_frame ? PH_LO : PH_IDLE;
        end else if (rd_en) begin
            unique case (phase_q)
                PH_LO: begin
                    hi_snap_q <= frame_q[FRAME_W-1:BYTE_W];
                    phase_q   <= PH_HI;
                end
                PH_HI:   phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_LO:   rd_val = frame_q[BYTE_W-1:0];
            PH_HI:   rd_val = {{PAD_W{1'b0}}, hi_snap_q};
            default: rd_val = '0;
        endcase
        rd_data = rd_en ? rd_val : '0;
    end
endmodule

// File: rtl/usbcp_in_flag.sv
module usbcp_in_flag (
    input  logic clk,
    input  logic rst,
    input  logic arm_pulse,
    input  logic in_token,
    input  logic host_ack,
    output logic buf_full,
    output logic in_reply_data,
    output logic in_reply_nak
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_full      <= 1'b0;
            in_reply_data <= 1'b0;
            in_reply_nak  <= 1'b0;
        end else begin
            in_reply_data <= in_token && buf_full;
            in_reply_nak  <= in_token && !buf_full;
            if (arm_pulse) begin
                buf_full <= 1'b1;
            end else if (host_ack) begin
                buf_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/usb_cmd_port.sv
module usb_cmd_port
    import usb_cmd_port_pkg::*;
#(
    parameter int         FRAME_W    = FRAME_W_DEF,
    parameter logic [7:0] CODE_ARM   = OP_ARM_IN,
    parameter logic [7:0] CODE_FRAME = OP_GET_FRAME
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_wr,
    input  logic [7:0]         cmd_byte,
    input  logic               rd_en,
    output logic [7:0]         rd_data,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               in_token,
    input  logic               host_ack,
    output logic               buf_full,
    output logic               in_reply_data,
    output logic               in_reply_nak
);
    logic [FRAME_W-1:0] frame_q;
    logic               arm_pulse;

    usbcp_frame_reg #(.FRAME_W(FRAME_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .sof_valid (sof_valid),
        .sof_frame (sof_frame),
        .frame_q   (frame_q)
    );

    usbcp_cmd_seq #(
        .FRAME_W    (FRAME_W),
        .CODE_ARM   (CODE_ARM),
        .CODE_FRAME (CODE_FRAME)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_byte  (cmd_byte),
        .rd_en     (rd_en),
        .frame_q   (frame_q),
        .rd_data   (rd_data),
        .arm_pulse (arm_pulse)
    );

    usbcp_in_flag u_flag (
        .clk           (clk),
        .rst           (rst),
        .arm_pulse     (arm_pulse),
        .in_token      (in_token),
        .host_ack      (host_ack),
        .buf_full      (buf_full),
        .in_reply_data (in_reply_data),
        .in_reply_nak  (in_reply_nak)
    );
endmodule

// File: rtl/usb_cmd_port_chk.sv
module usb_cmd_port_chk #(
    parameter logic [7:0] CODE_ARM   = 8'hFA,
    parameter logic [7:0] CODE_FRAME = 8'hF5
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wr,
    input logic [7:0] cmd_byte,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       in_token,
    input logic       host_ack,
    input logic       buf_full,
    input logic       in_reply_data,
    input logic       in_reply_nak
);
    logic [1:0] exp_ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_ph <= 2'd0;
        end else if (cmd_wr) begin
            exp_ph <= (cmd_byte == CODE_FRAME) ? 2'd1 : 2'd0;
        end else if (rd_en) begin
            exp_ph <= (exp_ph == 2'd1) ? 2'd2 : 2'd0;
        end
    end

    // R8
    flag_set_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> $past(cmd_wr && cmd_byte == CODE_ARM));

    // R9
    reply_data_chk: assert property (@(posedge clk) disable iff (rst)
        (in_token && buf_full) |=> (in_reply_data && buf_full));

    // R10
    reply_nak_chk: assert property (@(posedge clk) disable iff (rst)
        (in_token && !buf_full && !(cmd_wr && cmd_byte == CODE_ARM))
        |=> (in_reply_nak && !in_reply_data));

    // R11
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (host_ack && !(cmd_wr && cmd_byte == CODE_ARM)) |=> !buf_full);

    // R4
    hi_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !cmd_wr && exp_ph == 2'd2) |-> (rd_data[7:3] == 5'd0));

    // R7
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && exp_ph == 2'd0) |-> (rd_data == 8'h00));

    // R12
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == 8'h00));

    // R9
    reply_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_reply_data && in_reply_nak));
endmodule

bind usb_cmd_port usb_cmd_port_chk #(
    .CODE_ARM   (CODE_ARM),
    .CODE_FRAME (CODE_FRAME)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_wr        (cmd_wr),
    .cmd_byte      (cmd_byte),
    .rd_en         (rd_en),
    .rd_data       (rd_data),
    .in_token      (in_token),
    .host_ack      (host_ack),
    .buf_full      (buf_full),
    .in_reply_data (in_reply_data),
    .in_reply_nak  (in_reply_nak)
);

// File: tb/usb_cmd_port_tb.sv
module usb_cmd_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_frame = 11'h000;
    logic        in_token = 1'b0;
    logic        host_ack = 1'b0;
    logic        buf_full;
    logic        in_reply_data;
    logic        in_reply_nak;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usb_cmd_port u_dut (
        .clk           (clk),
        .rst           (rst),
        .cmd_wr        (cmd_wr),
        .cmd_byte      (cmd_byte),
        .rd_en         (rd_en),
        .rd_data       (rd_data),
        .sof_valid     (sof_valid),
        .sof_frame     (sof_frame),
        .in_token      (in_token),
        .host_ack      (host_ack),
        .buf_full      (buf_full),
        .in_reply_data (in_reply_data),
        .in_reply_nak  (in_reply_nak)
    );

    // {frame, expected first byte, expected second byte}
    localparam int NV = 6;
    localparam logic [26:0] VEC [NV] = '{
        {11'h000, 8'h00, 8'h00},
        {11'h7FF, 8'hFF, 8'h07},
        {11'h5A3, 8'hA3, 8'h05},
        {11'h100, 8'h00, 8'h01},
        {11'h0FF, 8'hFF, 8'h00},
        {11'h2C4, 8'hC4, 8'h02}
    };

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic finish_step();
        @(posedge clk);
        #1;
        cmd_wr = 1'b0; rd_en = 1'b0; sof_valid = 1'b0;
        in_token = 1'b0; host_ack = 1'b0;
    endtask

    task automatic do_cmd(input logic [7:0] op);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_byte = op;
        finish_step();
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        #2;
        v = rd_data;
        finish_step();
    endtask

    task automatic do_sof(input logic [10:0] f);
        @(negedge clk);
        sof_valid = 1'b1; sof_frame = f;
        finish_step();
    endtask

    task automatic do_token();
        @(negedge clk);
        in_token = 1'b1;
        finish_step();
    endtask

    initial begin
        logic [7:0] b;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check(buf_full == 1'b0, "R1 buf_full", {7'd0, buf_full}, 8'h00);
        do_cmd(8'hF5);
        do_read(b); check(b == 8'h00, "R1 frame lo", b, 8'h00);
        do_read(b); check(b == 8'h00, "R1 frame hi", b, 8'h00);

        // R2 R3 R4 table walk
        for (int i = 0; i < NV; i++) begin
            do_sof(VEC[i][26:16]);
            do_cmd(8'hF5);
            do_read(b); check(b == VEC[i][15:8], "R3 low byte", b, VEC[i][15:8]);
            do_read(b); check(b == VEC[i][7:0], "R4 high byte", b, VEC[i][7:0]);
        end

        // R2 latest of two SOFs
        do_sof(11'h123);
        do_sof(11'h456);
        do_cmd(8'hF5);
        do_read(b); check(b == 8'h56, "R2 latest lo", b, 8'h56);
        do_read(b); check(b == 8'h04, "R2 latest hi", b, 8'h04);

        // R7 third read empty
        do_read(b); check(b == 8'h00, "R7 third read", b, 8'h00);

        // R5 no tearing
        do_sof(11'h3FF);
        do_cmd(8'hF5);
        do_read(b); check(b == 8'hFF, "R5 lo", b, 8'hFF);
        do_sof(11'h400);
        do_read(b); check(b == 8'h03, "R5 hi snapshot", b, 8'h03);
        do_cmd(8'hF5);
        do_read(b); check(b == 8'h00, "R5 new lo", b, 8'h00);
        do_read(b); check(b == 8'h04, "R5 new hi", b, 8'h04);

        // R6 stop after one byte, restart
        do_sof(11'h6B2);
        do_cmd(8'hF5);
        do_read(b); check(b == 8'hB2, "R6 lo only", b, 8'hB2);
        do_cmd(8'hF5);
        do_read(b); check(b == 8'hB2, "R6 restart lo", b, 8'hB2);
        do_read(b); check(b == 8'h06, "R6 restart hi", b, 8'h06);

        // R10 NAK while empty
        do_token();
        check(in_reply_nak == 1'b1, "R10 nak", {7'd0, in_reply_nak}, 8'h01);
        check(in_reply_data == 1'b0, "R10 no data", {7'd0, in_reply_data}, 8'h00);

        // R6 R7 R8 abandon read with FA, then idle read
        do_cmd(8'hF5);
        do_read(b);
        do_cmd(8'hFA);
        check(buf_full == 1'b1, "R8 set", {7'd0, buf_full}, 8'h01);
        do_read(b); check(b == 8'h00, "R7 read after FA", b, 8'h00);
        check(buf_full == 1'b1, "R7 flag untouched", {7'd0, buf_full}, 8'h01);

        // R9 token while full
        do_token();
        check(in_reply_data == 1'b1, "R9 data", {7'd0, in_reply_data}, 8'h01);
        check(in_reply_nak == 1'b0, "R9 no nak", {7'd0, in_reply_nak}, 8'h00);
        check(buf_full == 1'b1, "R9 still full", {7'd0, buf_full}, 8'h01);
        #20;
        check(in_reply_data == 1'b0, "R9 one cycle", {7'd0, in_reply_data}, 8'h00);

        // R12 idle bus
        check(rd_data == 8'h00, "R12 rd_en low", rd_data, 8'h00);

        // R11 ack clears
        @(negedge clk); host_ack = 1'b1; finish_step();
        check(buf_full == 1'b0, "R11 cleared", {7'd0, buf_full}, 8'h00);

        // R11 ack with FA same cycle
        @(negedge clk); host_ack = 1'b1; cmd_wr = 1'b1; cmd_byte = 8'hFA; finish_step();
        check(buf_full == 1'b1, "R11 arm wins", {7'd0, buf_full}, 8'h01);

        // R1 reset again
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        check(buf_full == 1'b0, "R1 flag after reset", {7'd0, buf_full}, 8'h00);
        do_cmd(8'hF5);
        do_read(b); check(b == 8'h00, "R1 frame cleared", b, 8'h00);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        #5;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule